// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block shares one bus resource among a row of peripherals without a central priority encoder. Every peripheral is served by one identical cell, and the cells are wired in series. Requests ripple along the chain toward the resource end, where their combined OR is presented as a single request. The resource answers with one acknowledge. That acknowledge travels back along the chain in the other direction until it meets the first cell that wants it. Cell 0 sits next to the resource and wins every contest. Cell `N_CELLS-1` is at the far end and wins only when nobody else is asking.

Once a cell claims the acknowledge it becomes the owner. It keeps the grant for as long as its peripheral holds its request, and a request from a cell nearer the resource does not take the grant away. While a cell owns the grant, a hold flag flows toward the resource end. Cells nearer the resource then pass the acknowledge through rather than claiming it. When the owner drops its request, the arbiter needs one settling edge with no owner. After that, the highest-priority request still pending is granted.

To grow or shrink the system, change `N_CELLS`. No cell logic changes. An asynchronous active-low reset clears all ownership at once. Its release is synchronised to the clock.

Top module: `dchain_arb`

## Requirements
- R1: `bus_req_o` is high in the same cycle as any bit of `per_req_i`, and it is low when all request bits are low.
- R2: Suppose no grant is held and `bus_ack_i` is high at a rising edge. Then that edge grants the requesting peripheral with the lowest index, where bit 0 is nearest the resource.
- R3: At most one bit of `per_gnt_o` is high at any time.
- R4: A granted peripheral keeps its grant on every edge at which its request is still high. This holds even when a lower-index peripheral is requesting and whatever the level of `bus_ack_i`.
- R5: The first edge at which the owner's request is low clears its grant. That same edge issues no other grant, so the next winner is granted one edge later.
- R6: While no grant is held and `bus_ack_i` is low, no grant is issued.
- R7: A grant bit rises only if that peripheral's request was high at the edge that set it.
- R8: Asserting `rst_n` low clears every grant at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_req_i | input | N_CELLS | Request from each peripheral; bit 0 is nearest the resource |
| per_gnt_o | output | N_CELLS | Grant to each peripheral, one bit per cell |
| bus_req_o | output | 1 | Combined request presented to the shared resource |
| bus_ack_i | input | 1 | Acknowledge returned by the shared resource |

## Verification
`bus_req_o` is combinational, so it reflects the request pattern in the same cycle. Each grant change appears exactly one rising edge after the request and acknowledge levels that cause it. A hand-off therefore takes two edges: one to clear the old owner and one to set the new one. The driver applies each pattern at the falling edge and pushes the expected grant vector and combined request into a queue. The monitor pops the entry 1 ns after the next rising edge, so each comparison lands on the cycle in which that edge's result first becomes visible. The reset check is the exception. It samples half a nanosecond after `rst_n` falls, with no clock edge in between.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  // Ownership state held by each arbitration cell.
  typedef enum logic {
    CELL_IDLE = 1'b0,
    CELL_OWN  = 1'b1
  } cell_state_e;

  localparam int unsigned RST_STAGES_DEFAULT = 2;

endpackage

// File: rtl/dchain_rst_sync.sv
module dchain_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  // Assert immediately, release only after STAGES rising edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign srst_n = pipe_q[STAGES-1];

endmodule

// File: rtl/dchain_cell.sv
module dchain_cell
  import dchain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic own_req_i,   // local peripheral request
  input  logic up_req_i,    // requests from cells further from the resource
  output logic dn_req_o,    // requests toward the resource
  input  logic up_hold_i,   // a cell further out currently owns the grant
  output logic dn_hold_o,   // ownership flag toward the resource
  input  logic dn_ack_i,    // acknowledge arriving from the resource side
  output logic up_ack_o,    // acknowledge passed further out
  output logic gnt_o
);

  cell_state_e state_q;
  cell_state_e state_d;
  logic        owner;
  logic        claim;
  logic        win;
  logic        state_en;

  always_comb begin
    owner     = (state_q == CELL_OWN);
    win       = dn_ack_i & own_req_i & ~up_hold_i;
    // An owner keeps the acknowledge; an idle requester takes it unless
    // someone further out already owns the resource.
    claim     = owner | (own_req_i & ~up_hold_i);
    up_ack_o  = dn_ack_i & ~claim;
    dn_req_o  = own_req_i | up_req_i;
    dn_hold_o = owner | up_hold_i;
    state_en  = owner ? ~own_req_i : win;
    state_d   = owner ? CELL_IDLE : CELL_OWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CELL_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign gnt_o = owner;

endmodule

// File: rtl/dchain_arb.sv
module dchain_arb
  import dchain_pkg::*;
#(
  parameter int unsigned N_CELLS    = 4,
  parameter int unsigned RST_STAGES = RST_STAGES_DEFAULT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CELLS-1:0] per_req_i,
  output logic [N_CELLS-1:0] per_gnt_o,
  output logic               bus_req_o,
  input  logic               bus_ack_i
);

  localparam int unsigned LINKS = N_CELLS + 1;

  logic             srst_n;
  logic [LINKS-1:0] req_link;   // req_link[i] enters cell i-1 from cell i
  logic [LINKS-1:0] hold_link;
  logic [LINKS-1:0] ack_link;   // ack_link[i] enters cell i
  logic             unused_chain_ends;

  dchain_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign req_link[N_CELLS]  = 1'b0;
  assign hold_link[N_CELLS] = 1'b0;
  assign ack_link[0]        = bus_ack_i;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    dchain_cell u_cell (
      .clk       (clk),
      .rst_n     (srst_n),
      .own_req_i (per_req_i[i]),
      .up_req_i  (req_link[i+1]),
      .dn_req_o  (req_link[i]),
      .up_hold_i (hold_link[i+1]),
      .dn_hold_o (hold_link[i]),
      .dn_ack_i  (ack_link[i]),
      .up_ack_o  (ack_link[i+1]),
      .gnt_o     (per_gnt_o[i])
    );
  end

  assign bus_req_o         = req_link[0];
  assign unused_chain_ends = hold_link[0] ^ ack_link[N_CELLS];

endmodule

// File: rtl/dchain_arb_chk.sv
module dchain_arb_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] per_req_i,
  input logic [N-1:0] per_gnt_o,
  input logic         bus_req_o,
  input logic         bus_ack_i
);

  assert_bus_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o == (per_req_i != '0));

  assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (per_gnt_o == '0 && bus_ack_i && per_req_i != '0)
    |=> per_gnt_o == ($past(per_req_i) & (~$past(per_req_i) + 1'b1)));

  assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_gnt_o));

  assert_no_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (per_gnt_o == '0 && !bus_ack_i) |=> per_gnt_o == '0);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (per_gnt_o[i] && per_req_i[i]) |=> per_gnt_o[i]);

    assert_release_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (per_gnt_o[i] && !per_req_i[i]) |=> per_gnt_o == '0);

    assert_rise_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(per_gnt_o[i]) |-> $past(per_req_i[i]));
  end

endmodule

bind dchain_arb dchain_arb_chk #(.N(N_CELLS)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .per_req_i (per_req_i),
  .per_gnt_o (per_gnt_o),
  .bus_req_o (bus_req_o),
  .bus_ack_i (bus_ack_i)
);

// File: tb/sim_dchain_arb.sv
`timescale 1ns/1ps
module sim_dchain_arb;

  localparam int N = 4;

  typedef struct {
    logic [N-1:0] gnt;
    logic         breq;
    logic [N-1:0] req;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] per_req;
  logic [N-1:0] per_gnt;
  logic         bus_req;
  logic         bus_ack;

  exp_t         sb[$];
  logic [N-1:0] m_own;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done  = 0;

  always #2 clk = ~clk;

  dchain_arb #(.N_CELLS(N)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_req_i (per_req),
    .per_gnt_o (per_gnt),
    .bus_req_o (bus_req),
    .bus_ack_i (bus_ack)
  );

  // Driver: apply a pattern at the falling edge and queue the predicted result.
  task automatic step(input logic [N-1:0] r, input logic a, input string tag);
    exp_t e;
    logic [N-1:0] nxt;
    @(negedge clk);
    per_req = r;
    bus_ack = a;
    if (m_own != '0) nxt = ((m_own & r) != '0) ? m_own : '0;
    else if (a && r != '0) nxt = r & (~r + 1'b1);
    else nxt = '0;
    m_own  = nxt;
    e.gnt  = nxt;
    e.breq = (r != '0);
    e.req  = r;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // Monitor: one rising edge after each pattern, compare what the edge produced.
  always begin
    exp_t e;
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      n_cmp++;
      if (per_gnt !== e.gnt) begin
        n_bad++;
        $display("FAIL %s grant got %b exp %b", e.tag, per_gnt, e.gnt);
      end
      n_cmp++;
      if (bus_req !== e.breq) begin
        n_bad++;
        $display("FAIL R1 bus_req got %b exp %b", bus_req, e.breq);
      end
      n_cmp++;
      if ($countones(per_gnt) > 1) begin
        n_bad++;
        $display("FAIL R3 grant got %b exp at most one bit", per_gnt);
      end
      n_cmp++;
      if ((per_gnt & ~e.req) != '0) begin
        n_bad++;
        $display("FAIL R7 grant got %b exp subset of %b", per_gnt, e.req);
      end
    end
  end

  task automatic check_now(input logic [N-1:0] expv, input string tag);
    n_cmp++;
    if (per_gnt !== expv) begin
      n_bad++;
      $display("FAIL %s grant got %b exp %b", tag, per_gnt, expv);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    per_req = '1;
    bus_ack = 1'b1;
    m_own   = '0;
    repeat (3) @(negedge clk);
    check_now('0, "R8 reset");
    per_req = '0;
    rst_n   = 1'b1;
    repeat (4) @(negedge clk);
    check_now('0, "R8 after release");

    step(4'b0000, 1'b1, "R2 idle");
    step(4'b0100, 1'b1, "R2 single");
    step(4'b0110, 1'b1, "R4 higher arrives");
    step(4'b0111, 1'b1, "R4 highest arrives");
    step(4'b0011, 1'b1, "R5 release gap");
    step(4'b0011, 1'b1, "R2 next winner");
    step(4'b1011, 1'b1, "R4 hold");
    step(4'b1010, 1'b1, "R5 release gap");
    step(4'b1010, 1'b1, "R2 next winner");
    step(4'b1000, 1'b1, "R5 release gap");
    step(4'b1000, 1'b1, "R2 far end");
    step(4'b0000, 1'b1, "R5 drop");
    step(4'b0101, 1'b0, "R6 no ack");
    step(4'b0101, 1'b0, "R6 no ack");
    step(4'b0101, 1'b1, "R2 ack arrives");
    step(4'b0101, 1'b0, "R4 ack drops");
    step(4'b0100, 1'b0, "R5 release");
    step(4'b0100, 1'b0, "R6 no ack");
    step(4'b0000, 1'b1, "R5 idle");
    for (int k = 0; k < 16; k++) begin
      step(k[N-1:0], 1'b1, "R2 R4 R5 sweep");
      step(k[N-1:0], 1'b1, "R2 R4 R5 sweep");
      step(~k[N-1:0], (k % 3) != 0, "R4 R6 sweep");
    end
    step(4'b0010, 1'b1, "R2 before reset");
    step(4'b0010, 1'b1, "R4 before reset");
    wait (sb.size() == 0);
    @(posedge clk);
    #1.5;
    rst_n = 1'b0;
    #0.5;
    check_now('0, "R8 async clear");
    @(negedge clk);
    per_req = '0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule